// File: doc/BRIEF.md
# Windowed SAD Stereo Disparity Engine

This block estimates horizontal disparity between two rectified grayscale images. The left and right 8-bit pixel streams arrive together in raster order, one pixel of each per accepted clock. Each stream passes through a shift-style store that holds two full rows plus a short column span. This gives a 3x3 window around the current left pixel and every shifted 3x3 window of the right image at the same moment.

For each candidate shift from 0 to `DMAX`, a separate cost unit adds up the nine absolute pixel differences. All candidates are evaluated in the same cycle. A binary tree of comparator-driven multiplexers picks the cheapest shift, and that index is the disparity. The result is registered with a valid flag a fixed two cycles after the pixel that completes the window. Image width, image height and `DMAX` are parameters.

The stream is treated as continuous across frames. The last few centres of a frame are emitted as the next frame's first pixels arrive.

Top module: `sad_disparity_top`

## Requirements
- R1: A pixel pair is taken in only on a clock where `in_valid` is high. While `in_valid` is low the stored image data and the position tracking do not move, so idle gaps change neither the output values nor their order.
- R2: The cost of shift s at centre (x,y) is the sum, over row and column offsets u,v in {-1,0,1}, of |L(x+u,y+v) - R(x+u+s,y+v)|.
- R3: `out_disp` carries the shift with the smallest cost, zero-extended to `DISP_W` bits, so it never exceeds `DMAX`.
- R4: When several shifts share the smallest cost, the smallest of those shifts is reported.
- R5: A shift s with x+1+s > IMG_W-1 reaches past the right end of the row and is never chosen. At x = IMG_W-2 the output is therefore always 0.
- R6: An output is produced only for centres with 1 <= x <= IMG_W-2 and 1 <= y <= IMG_H-2. There is exactly one output per such centre, in raster order, which is (IMG_W-2)*(IMG_H-2) outputs per frame.
- R7: The output for centre (x,y) is presented with `out_valid` high starting 2 clock cycles after the rising edge that accepts the pixel at continuous raster index (y+1)*IMG_W + x + DMAX + 1. Frame length is counted in that index, so it carries on into the next frame.
- R8: During reset and after it, until the first result, `out_valid` is low and `out_disp` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | High when a left/right pixel pair is presented |
| left_pix | input | 8 | Left image grayscale pixel |
| right_pix | input | 8 | Right image grayscale pixel |
| out_valid | output | 1 | High for one cycle per produced disparity |
| out_disp | output | DISP_W | Winning shift, zero-extended |

## Verification
The bench targets these corner cases and the failure each would reveal:

- **Flat images.** Every shift costs zero, so a tie-break that favoured later candidates would report `DMAX` instead of 0.
- **Shift of `DMAX` between the images.** The true match near the right border falls off the row. A design that forgot to exclude those shifts would match against pixels of the following row and report a large disparity at x = IMG_W-2.
- **Irregular idle gaps, including one long stall.** A design that advanced its window or position counters on idle cycles would emit outputs with the wrong values or at the wrong cycles.
- **Output count per frame.** A design that leaked border centres, or dropped the centres that complete only after the frame ends, would show the wrong count.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int PIX_W    = 8;
  localparam int WIN_TAPS = 9;
  localparam int COST_W   = PIX_W + $clog2(WIN_TAPS);

  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [COST_W-1:0] cost_t;

  // Larger than any real 3x3 cost (9 * 255), used for excluded shifts.
  localparam cost_t COST_MAX = '1;

  function automatic pix_t abs_diff(input pix_t a, input pix_t b);
    return (a > b) ? pix_t'(a - b) : pix_t'(b - a);
  endfunction

  function automatic cost_t widen(input pix_t d);
    return cost_t'(d);
  endfunction
endpackage

// File: rtl/sad_row_store.sv
// Shift-style storage: two full row delays plus a column span.
// Output win[j][i] is the pixel j rows and (SKIP+i) columns behind the newest.
module sad_row_store
  import sad_pkg::*;
#(
  parameter int ROW_LEN = 32,
  parameter int SPAN    = 10,
  parameter int SKIP    = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  pix_t din,
  output pix_t win [3][SPAN-SKIP]
);
  localparam int DEPTH = 2 * ROW_LEN + SPAN;
  localparam int NOUT  = SPAN - SKIP;

  pix_t sr_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
    end else if (shift_en) begin
      sr_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  for (genvar j = 0; j < 3; j++) begin : g_row
    for (genvar i = 0; i < NOUT; i++) begin : g_col
      assign win[j][i] = sr_q[j*ROW_LEN + SKIP + i];
    end
  end
endmodule

// File: rtl/sad_cost_unit.sv
// One candidate shift: 3x3 sum of absolute differences, forced to COST_MAX when cut.
module sad_cost_unit
  import sad_pkg::*;
(
  input  pix_t  lwin [WIN_TAPS],
  input  pix_t  rwin [WIN_TAPS],
  input  logic  cut,
  output cost_t cost
);
  cost_t acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < WIN_TAPS; i++) acc = acc + widen(abs_diff(lwin[i], rwin[i]));
    cost = cut ? COST_MAX : acc;
  end
endmodule

// File: rtl/sad_min_tree.sv
// Arg-min as a heap of comparator-driven muxes; on equal cost the lower index wins.
module sad_min_tree
  import sad_pkg::*;
#(
  parameter int NCAND = 8,
  parameter int IDX_W = 3
) (
  input  cost_t             cost [NCAND],
  output logic [IDX_W-1:0]  win_idx,
  output cost_t             win_cost
);
  localparam int P = 1 << IDX_W;

  cost_t            hc [1:2*P-1];
  logic [IDX_W-1:0] hi [1:2*P-1];

  for (genvar n = 0; n < P; n++) begin : g_leaf
    if (n < NCAND) begin : g_real
      assign hc[P+n] = cost[n];
    end else begin : g_pad
      assign hc[P+n] = COST_MAX;
    end
    assign hi[P+n] = IDX_W'(n);
  end

  for (genvar n = 1; n < P; n++) begin : g_node
    logic take_b;
    assign take_b = hc[2*n] > hc[2*n+1];
    assign hc[n]  = take_b ? hc[2*n+1] : hc[2*n];
    assign hi[n]  = take_b ? hi[2*n+1] : hi[2*n];
  end

  assign win_cost = hc[1];
  assign win_idx  = hi[1];
endmodule

// File: rtl/sad_disparity_top.sv
module sad_disparity_top
  import sad_pkg::*;
#(
  parameter int IMG_W  = 32,
  parameter int IMG_H  = 24,
  parameter int DMAX   = 7,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        left_pix,
  input  logic [7:0]        right_pix,
  output logic              out_valid,
  output logic [DISP_W-1:0] out_disp
);
  localparam int NCAND = DMAX + 1;
  localparam int SPAN  = DMAX + 3;
  localparam int PRIME = DMAX + 1;
  localparam int XW    = $clog2(IMG_W);
  localparam int YW    = $clog2(IMG_H);
  localparam int PW    = $clog2(PRIME + 1);
  localparam int IDX_W = (NCAND > 1) ? $clog2(NCAND) : 1;

  // ---------------- window storage ----------------
  pix_t lcols [3][3];
  pix_t rcols [3][SPAN];

  sad_row_store #(.ROW_LEN(IMG_W), .SPAN(SPAN), .SKIP(DMAX)) u_left_store (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .din(left_pix), .win(lcols));

  sad_row_store #(.ROW_LEN(IMG_W), .SPAN(SPAN), .SKIP(0)) u_right_store (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .din(right_pix), .win(rcols));

  // ---------------- centre tracking ----------------
  // lx_q / lr_q: column and lowest window row of the centre the next shift completes.
  logic [PW-1:0] prime_q;
  logic [XW-1:0] lx_q, win_x_q;
  logic [YW-1:0] lr_q;
  logic          primed, centre_ok, win_vld_q;

  assign primed    = (prime_q == PW'(PRIME));
  assign centre_ok = in_valid && primed &&
                     (lx_q >= XW'(1)) && (lx_q <= XW'(IMG_W-2)) && (lr_q >= YW'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prime_q   <= '0;
      lx_q      <= '0;
      lr_q      <= '0;
      win_x_q   <= '0;
      win_vld_q <= 1'b0;
    end else begin
      win_vld_q <= centre_ok;
      if (in_valid && !primed) prime_q <= prime_q + 1'b1;
      if (in_valid && primed) begin
        win_x_q <= lx_q;
        if (lx_q == XW'(IMG_W-1)) begin
          lx_q <= '0;
          lr_q <= (lr_q == YW'(IMG_H-1)) ? '0 : lr_q + 1'b1;
        end else begin
          lx_q <= lx_q + 1'b1;
        end
      end
    end
  end

  // ---------------- candidate costs ----------------
  cost_t      cand_cost [NCAND];
  cost_t      cand_cost_q [NCAND];
  logic [NCAND-1:0] edge_cut;
  logic       cost_vld_q;

  for (genvar s = 0; s < NCAND; s++) begin : g_cand
    pix_t lw [WIN_TAPS];
    pix_t rw [WIN_TAPS];
    for (genvar j = 0; j < 3; j++) begin : g_r
      for (genvar u = 0; u < 3; u++) begin : g_c
        // column offset (u-1) sits DMAX+2-u positions behind the newest pixel
        assign lw[j*3+u] = lcols[j][2-u];
        assign rw[j*3+u] = rcols[j][DMAX+2-u-s];
      end
    end
    assign edge_cut[s] = (32'(win_x_q) + 1 + s) > (IMG_W - 1);
    sad_cost_unit u_cost (.lwin(lw), .rwin(rw), .cut(edge_cut[s]), .cost(cand_cost[s]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cost_vld_q <= 1'b0;
      for (int i = 0; i < NCAND; i++) cand_cost_q[i] <= '0;
    end else begin
      cost_vld_q <= win_vld_q;
      for (int i = 0; i < NCAND; i++) cand_cost_q[i] <= cand_cost[i];
    end
  end

  // ---------------- selection ----------------
  logic [IDX_W-1:0] min_idx;
  cost_t            min_cost;

  sad_min_tree #(.NCAND(NCAND), .IDX_W(IDX_W)) u_min (
    .cost(cand_cost_q), .win_idx(min_idx), .win_cost(min_cost));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_disp  <= '0;
    end else begin
      out_valid <= cost_vld_q;
      if (cost_vld_q) out_disp <= DISP_W'(min_idx);
    end
  end
endmodule

// File: rtl/sad_disparity_chk.sv
module sad_disparity_chk
  import sad_pkg::*;
#(
  parameter int IMG_W  = 32,
  parameter int IMG_H  = 24,
  parameter int DMAX   = 7,
  parameter int DISP_W = 8,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic [DISP_W-1:0] out_disp,
  input logic              cand_vld,
  input cost_t             cand_cost [DMAX+1],
  input cost_t             min_cost,
  input logic [IDX_W-1:0]  min_idx
);
  // Independent position model: centre = newest accepted pixel minus DMAX+1.
  int   ic_q, ir_q, seen_q, qx, qr;
  logic exp_now, e0_q, e1_q, e2_q;

  always_comb begin
    if (ic_q >= DMAX + 1) begin
      qx = ic_q - DMAX - 1;
      qr = ir_q;
    end else begin
      qx = ic_q + IMG_W - DMAX - 1;
      qr = (ir_q == 0) ? IMG_H - 1 : ir_q - 1;
    end
    exp_now = in_valid && (seen_q >= DMAX + 1) && (qx >= 1) && (qx <= IMG_W - 2) && (qr >= 2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ic_q <= 0; ir_q <= 0; seen_q <= 0;
      e0_q <= 1'b0; e1_q <= 1'b0; e2_q <= 1'b0;
    end else begin
      e0_q <= exp_now;
      e1_q <= e0_q;
      e2_q <= e1_q;
      if (in_valid) begin
        if (seen_q < DMAX + 1) seen_q <= seen_q + 1;
        if (ic_q == IMG_W - 1) begin
          ic_q <= 0;
          ir_q <= (ir_q == IMG_H - 1) ? 0 : ir_q + 1;
        end else begin
          ic_q <= ic_q + 1;
        end
      end
    end
  end

  assert_disp_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_disp) <= DMAX));

  assert_border_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == e2_q);

  assert_valid_after_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));

  for (genvar i = 0; i <= DMAX; i++) begin : g_cand
    assert_min_not_above_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cand_vld |-> (min_cost <= cand_cost[i]));
    assert_tie_lower_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_vld && (int'(min_idx) > i)) |-> (cand_cost[i] > min_cost));
  end
endmodule

bind sad_disparity_top sad_disparity_chk #(
  .IMG_W(IMG_W), .IMG_H(IMG_H), .DMAX(DMAX), .DISP_W(DISP_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_disp(out_disp),
  .cand_vld(cost_vld_q), .cand_cost(cand_cost_q),
  .min_cost(min_cost), .min_idx(min_idx)
);

// File: tb/sad_disparity_top_tb.sv
module sad_disparity_top_tb;
  localparam int W    = 32;
  localparam int H    = 8;
  localparam int D    = 7;
  localparam int NPIX = W * H;
  localparam int NTOT = NPIX + W;
  localparam int NEXP = (W - 2) * (H - 2);
  localparam int NMAX = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] left_pix = '0, right_pix = '0;
  logic       out_valid;
  logic [7:0] out_disp;

  always #4 clk = ~clk;

  sad_disparity_top #(.IMG_W(W), .IMG_H(H), .DMAX(D), .DISP_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .left_pix(left_pix), .right_pix(right_pix),
    .out_valid(out_valid), .out_disp(out_disp));

  int checks = 0, errors = 0, cyc = 0, n_out = 0, seed = 1;
  int lim [NTOT];
  int rim [NTOT];
  int acc_cyc [NTOT];
  int out_d [NMAX];
  int out_c [NMAX];
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (n_out < NMAX) begin
        out_d[n_out] = int'(out_disp);
        out_c[n_out] = cyc;
      end
      n_out = n_out + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rnd8();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 255;
  endfunction

  function automatic int tex(input int x, input int y);
    int h;
    h = x * 73 + y * 151 + 11;
    return (h * h + 17 * x + 5 * y) % 251;
  endfunction

  // Reference: lowest 3x3 SAD over shifts whose right window stays inside the row.
  function automatic int ref_disp(input int x, input int y);
    int best, bestc, c, a, b;
    best = -1; bestc = 0;
    for (int s = 0; s <= D; s++) begin
      if (x + 1 + s <= W - 1) begin
        c = 0;
        for (int v = -1; v <= 1; v++)
          for (int u = -1; u <= 1; u++) begin
            a = lim[(y+v)*W + x + u];
            b = rim[(y+v)*W + x + u + s];
            c += (a > b) ? a - b : b - a;
          end
        if (best < 0 || c < bestc) begin best = s; bestc = c; end
      end
    end
    return best;
  endfunction

  // kind 0: random, 1: right = left moved right by p, 2: flat
  task automatic fill(input int kind, input int p);
    for (int i = 0; i < NTOT; i++) begin
      int x, y;
      x = i % W; y = i / W;
      if (i >= NPIX) begin
        lim[i] = 0; rim[i] = 0;
      end else if (kind == 0) begin
        lim[i] = rnd8(); rim[i] = rnd8();
      end else if (kind == 1) begin
        lim[i] = tex(x, y);
        rim[i] = (x >= p) ? tex(x - p, y) : tex(x + 40, y);
      end else begin
        lim[i] = 100; rim[i] = 100;
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_out = 0;
  endtask

  task automatic stream(input bit gaps);
    for (int i = 0; i < NTOT; i++) begin
      if (gaps && (i % 3 == 1)) begin @(negedge clk); in_valid = 1'b0; end
      if (gaps && i == 100) begin
        in_valid = 1'b0;
        repeat (20) @(negedge clk);
      end
      @(negedge clk);
      in_valid = 1'b1;
      left_pix = 8'(lim[i]);
      right_pix = 8'(rim[i]);
      acc_cyc[i] = cyc + 1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_frame(input string req, input bit lat);
    int k;
    check("R6 output count", n_out, NEXP);
    k = 0;
    for (int y = 1; y <= H - 2; y++)
      for (int x = 1; x <= W - 2; x++) begin
        if (k < n_out && k < NMAX) begin
          check(req, out_d[k], ref_disp(x, y));
          if (lat) check("R7 latency", out_c[k], acc_cyc[(y+1)*W + x + D + 1] + 2);
        end
        k++;
      end
  endtask

  task automatic test_reset_r8();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 out_valid in reset", int'(out_valid), 0);
    check("R8 out_disp in reset", int'(out_disp), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 out_valid after reset", int'(out_valid), 0);
    check("R8 out_disp after reset", int'(out_disp), 0);
  endtask

  task automatic test_shift_r3();
    do_reset(); fill(1, 3); stream(1'b0);
    check_frame("R2/R3 shift 3", 1'b0);
    check("R3 interior shift value", out_d[2*(W-2) + 10], 3);
  endtask

  task automatic test_random_r2();
    do_reset(); fill(0, 0); stream(1'b0);
    check_frame("R2/R3 random", 1'b0);
  endtask

  task automatic test_flat_r4();
    do_reset(); fill(2, 0); stream(1'b0);
    check_frame("R4 flat tie", 1'b0);
    check("R4 tie picks shift 0", out_d[NEXP/2], 0);
  endtask

  task automatic test_edge_r5();
    do_reset(); fill(1, D); stream(1'b0);
    check_frame("R5 edge clip", 1'b0);
    check("R5 last column", out_d[W-3], 0);
    check("R5 full-range interior", out_d[3], D);
  endtask

  task automatic test_gaps_r1();
    do_reset(); fill(0, 0); stream(1'b1);
    check_frame("R1 gaps", 1'b1);
  endtask

  initial begin
    test_reset_r8();
    test_shift_r3();
    test_random_r2();
    test_flat_r4();
    test_edge_r5();
    test_gaps_r1();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule